// File: doc/BRIEF.md
# Three-Byte Readout Host Interface

This block is the bus-facing front end of a high-resolution integrating converter. A host on an 8-bit bus controls it with three active-low or level strobes and reads a 24-bit result in three byte-wide steps. One falling edge on the convert line starts a conversion when the block is idle. While the conversion runs, the block waits for a done strobe from the conversion engine. Later falling edges on the same line step the output register from the high byte to the middle byte and then to the low byte. A two-bit status code tells the host which of these steps the block is in.

The same strobes also program the operating mode. The host first qualifies a write with the mode line and latches a byte with a low pulse on output enable. The next convert edge then applies the new settings. During this settling time the status reads low and no conversion is requested. An active-low auto-zero/reset input restores the default settings. It holds the engine in auto-zero for a fixed time after release, and the block goes through the same sequence on power-up.

All host inputs pass through two-stage synchronisers, and edges are detected on the synchronised copies. The result is bipolar offset binary, right-aligned at the active resolution. Bits above the active resolution are forced to zero.

Top module: `conv_host_if`

## Requirements
- R1: In the ready state (status 11), a falling edge on conv_ni with no mode write pending sets status to 00 within three rising clock edges and pulses start_o for exactly one cycle.
- R2: A done_i pulse while a conversion is in progress sets status to 01 and loads the most significant byte (result bits 23:16 after masking) into data_o.
- R3: In status 01, the next conv_ni falling edge loads result bits 15:8 and sets status 10. In status 10, the next falling edge loads bits 7:0 and returns status to 11.
- R4: data_oe_o is high only while the synchronised oe_ni is low and the synchronised mode_i is low. It is low at all other times, including during a mode write.
- R5: Mode byte fields: bits 5:4 source (00 main input with auto-zero, 01 alternate input), bit 3 line frequency (0 = 60 Hz, 1 = 50 Hz), bits 2:0 resolution (001 = 18, 010 = 20, 011 = 22, 100 = 24 bits). Bits 7:6 are ignored. These fields drive src_o, line50_o and res_o.
- R6: A mode byte is latched from data_i only in status 11, on an oe_ni falling edge while mode_i is high. The next conv_ni falling edge applies it, starts no conversion, and holds status at 00 for SETTLE_CYC cycles before returning to 11.
- R7: A mode write with resolution code 000 or 101 to 111 is discarded. The settings stay unchanged, and the next conv_ni falling edge starts a normal conversion.
- R8: While az_ni is low, and for AZ_CYC cycles after it returns high, status is 00 and az_o is high. The settings take the defaults: res_o 011, line50_o 0, src_o 00. After reset the block behaves the same way.
- R9: The result is masked to the active resolution. At 22 bits the mid-scale code 0x200000 reads 20 00 00, and at 18 bits an all-ones engine word reads 03 FF FF.
- R10: done_i outside a conversion in progress is ignored, and data_o and status_o keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_ni | input | 1 | Convert strobe, falling edge active |
| oe_ni | input | 1 | Output enable, active low; also the mode-write strobe |
| mode_i | input | 1 | Qualifies oe_ni pulses as mode writes |
| az_ni | input | 1 | Auto-zero/reset, active low |
| data_i | input | 8 | Bus value sampled on a mode write |
| data_o | output | 8 | Output register contents |
| data_oe_o | output | 1 | Bus driver enable for data_o |
| status_o | output | 2 | Progress code {S1,S0} |
| start_o | output | 1 | One-cycle conversion request to the engine |
| az_o | output | 1 | Auto-zero request to the engine |
| done_i | input | 1 | Engine conversion-complete strobe |
| result_i | input | 24 | Engine result word, offset binary |
| src_o | output | 2 | Active input source selection |
| line50_o | output | 1 | Active line frequency, 1 = 50 Hz |
| res_o | output | 3 | Active resolution code |

## Verification
The hardest case to reach is a mode byte arriving while the block is idle, followed by a convert edge. From the ports this edge looks the same as a conversion start. The block has to tell the two apart using only the latched write. The bench performs the full handshake: mode high, an oe pulse with the byte held on data_i, then a convert pulse. It checks that start_o never pulses, that status reads 00 through the settling window, and that the new fields appear. It repeats the handshake with a reserved resolution code to show that the same convert edge then starts a conversion instead.

// File: rtl/conv_if_pkg.sv
package conv_if_pkg;
  localparam int RES_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_READY, ST_CONV, ST_MSB, ST_MID, ST_SETTLE, ST_AZ
  } seq_state_e;

  typedef struct packed {
    logic [1:0] src;
    logic       line50;
    logic [2:0] res;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_DEFAULT = '{src: 2'b00, line50: 1'b0, res: 3'b011};

  function automatic logic res_code_ok(logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  function automatic int unsigned res_bits(logic [2:0] c);
    return 16 + 2 * int'(c);
  endfunction

  function automatic logic [RES_W-1:0] res_mask(logic [2:0] c);
    logic [RES_W-1:0] m;
    m = '0;
    for (int i = 0; i < RES_W; i++) m[i] = (i < res_bits(c));
    return m;
  endfunction
endpackage

// File: rtl/cif_sync_fall.sv
module cif_sync_fall #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic m_q, s_q, p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q <= RST_VAL[g];
        s_q <= RST_VAL[g];
        p_q <= RST_VAL[g];
      end else begin
        m_q <= d_i[g];
        s_q <= m_q;
        p_q <= s_q;
      end
    end
    assign s_o[g]    = s_q;
    assign fall_o[g] = p_q & ~s_q;
  end
endmodule

// File: rtl/cif_mode.sv
module cif_mode
  import conv_if_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      az_s_i,
  input  logic      oe_fall_i,
  input  logic      mode_s_i,
  input  logic      ready_i,
  input  logic      apply_i,
  input  logic [7:0] data_i,
  output mode_cfg_t cfg_o,
  output logic      pend_o
);
  mode_cfg_t cfg_q, new_q;
  logic      pend_q;
  logic      unused_hi;

  assign unused_hi = ^data_i[7:6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_DEFAULT;
      new_q  <= CFG_DEFAULT;
      pend_q <= 1'b0;
    end else if (!az_s_i) begin
      cfg_q  <= CFG_DEFAULT;
      pend_q <= 1'b0;
    end else if (apply_i) begin
      cfg_q  <= new_q;
      pend_q <= 1'b0;
    end else if (ready_i && oe_fall_i && mode_s_i && res_code_ok(data_i[2:0])) begin
      new_q  <= '{src: data_i[5:4], line50: data_i[3], res: data_i[2:0]};
      pend_q <= 1'b1;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cif_seq.sv
module cif_seq
  import conv_if_pkg::*;
#(
  parameter int AZ_CYC     = 8,
  parameter int SETTLE_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_fall_i,
  input  logic             az_s_i,
  input  logic             pend_i,
  input  logic [2:0]       res_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output seq_state_e       state_o,
  output logic [1:0]       status_o,
  output logic [7:0]       data_o,
  output logic             start_o,
  output logic             az_o,
  output logic             apply_o
);
  localparam int CNT_MAX = (AZ_CYC > SETTLE_CYC) ? AZ_CYC : SETTLE_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [RES_W-1:0] res_q, masked;
  logic [7:0]       out_q;
  logic             start_q;

  assign masked = result_i & res_mask(res_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AZ;
      cnt_q   <= CW'(AZ_CYC - 1);
      res_q   <= '0;
      out_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!az_s_i) begin
        state_q <= ST_AZ;
        cnt_q   <= CW'(AZ_CYC - 1);
      end else begin
        unique case (state_q)
          ST_READY: if (conv_fall_i) begin
            if (pend_i) begin
              state_q <= ST_SETTLE;
              cnt_q   <= CW'(SETTLE_CYC - 1);
            end else begin
              state_q <= ST_CONV;
              start_q <= 1'b1;
            end
          end
          ST_CONV: if (done_i) begin
            res_q   <= masked;
            out_q   <= masked[RES_W-1 -: BYTE_W];
            state_q <= ST_MSB;
          end
          ST_MSB: if (conv_fall_i) begin
            out_q   <= res_q[2*BYTE_W-1 -: BYTE_W];
            state_q <= ST_MID;
          end
          ST_MID: if (conv_fall_i) begin
            out_q   <= res_q[BYTE_W-1:0];
            state_q <= ST_READY;
          end
          ST_SETTLE, ST_AZ: begin
            if (cnt_q == '0) state_q <= ST_READY;
            else cnt_q <= cnt_q - 1'b1;
          end
          default: state_q <= ST_READY;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READY: status_o = 2'b11;
      ST_MSB:   status_o = 2'b01;
      ST_MID:   status_o = 2'b10;
      default:  status_o = 2'b00;
    endcase
  end

  assign apply_o = az_s_i && (state_q == ST_READY) && conv_fall_i && pend_i;
  assign state_o = state_q;
  assign data_o  = out_q;
  assign start_o = start_q;
  assign az_o    = (state_q == ST_AZ);
endmodule

// File: rtl/conv_host_if.sv
module conv_host_if
  import conv_if_pkg::*;
#(
  parameter int AZ_CYC     = 8,
  parameter int SETTLE_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_ni,
  input  logic             oe_ni,
  input  logic             mode_i,
  input  logic             az_ni,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic [1:0]       status_o,
  output logic             start_o,
  output logic             az_o,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [1:0]       src_o,
  output logic             line50_o,
  output logic [2:0]       res_o
);
  logic [3:0] sync_s, sync_fall;
  logic       conv_fall, oe_s, oe_fall, mode_s, az_s;
  logic       pend, apply;
  mode_cfg_t  cfg;
  seq_state_e state_q;

  // bit order {az, mode, oe, conv}
  cif_sync_fall #(.W(4), .RST_VAL(4'b1011)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({az_ni, mode_i, oe_ni, conv_ni}),
    .s_o   (sync_s), .fall_o (sync_fall)
  );

  assign conv_fall = sync_fall[0];
  assign oe_s      = sync_s[1];
  assign oe_fall   = sync_fall[1];
  assign mode_s    = sync_s[2];
  assign az_s      = sync_s[3];

  cif_mode u_mode (
    .clk_i (clk_i), .rst_ni (rst_ni), .az_s_i (az_s),
    .oe_fall_i (oe_fall), .mode_s_i (mode_s),
    .ready_i (state_q == ST_READY), .apply_i (apply),
    .data_i (data_i), .cfg_o (cfg), .pend_o (pend)
  );

  cif_seq #(.AZ_CYC(AZ_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .conv_fall_i (conv_fall),
    .az_s_i (az_s), .pend_i (pend), .res_i (cfg.res),
    .done_i (done_i), .result_i (result_i), .state_o (state_q),
    .status_o (status_o), .data_o (data_o), .start_o (start_o),
    .az_o (az_o), .apply_o (apply)
  );

  assign data_oe_o = ~oe_s & ~mode_s;
  assign src_o     = cfg.src;
  assign line50_o  = cfg.line50;
  assign res_o     = cfg.res;
endmodule

// File: rtl/cif_chk.sv
module cif_chk
  import conv_if_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] status_o,
  input logic       start_o,
  input logic       done_i,
  input logic [7:0] data_o,
  input logic [2:0] res_o,
  input logic       az_o,
  input logic       az_s,
  input seq_state_e state_q
);
  // R1
  r1_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (status_o == 2'b00) && ($past(status_o) == 2'b11));

  // R2
  r2_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && done_i && az_s) |=> (status_o == 2'b01));

  // R3
  r3_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b10 && $past(status_o) != 2'b10) |-> ($past(status_o) == 2'b01));

  // R5
  r5_res_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o >= 3'd1) && (res_o <= 3'd4));

  // R8
  r8_az_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !az_s |=> (status_o == 2'b00) && az_o && (res_o == 3'b011));

  // R10
  r10_done_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b11 && done_i) |=> $stable(data_o));
endmodule

bind conv_host_if cif_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .status_o (status_o), .start_o (start_o),
  .done_i (done_i), .data_o (data_o), .res_o (res_o), .az_o (az_o),
  .az_s (az_s), .state_q (state_q)
);

// File: tb/conv_host_if_test.sv
`timescale 1ns/1ps
module conv_host_if_test;
  localparam int AZ_CYC = 8;
  localparam int SETTLE_CYC = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic conv_ni = 1'b1, oe_ni = 1'b1, mode_i = 1'b0, az_ni = 1'b1;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic data_oe_o, start_o, az_o, done_i = 1'b0, line50_o;
  logic [1:0] status_o, src_o;
  logic [23:0] result_i = '0;
  logic [2:0] res_o;
  int n_chk = 0, n_fail = 0, n_start = 0;

  always #2.5 clk = ~clk;

  conv_host_if #(.AZ_CYC(AZ_CYC), .SETTLE_CYC(SETTLE_CYC)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .conv_ni (conv_ni), .oe_ni (oe_ni),
    .mode_i (mode_i), .az_ni (az_ni), .data_i (data_i), .data_o (data_o),
    .data_oe_o (data_oe_o), .status_o (status_o), .start_o (start_o),
    .az_o (az_o), .done_i (done_i), .result_i (result_i), .src_o (src_o),
    .line50_o (line50_o), .res_o (res_o)
  );

  always @(posedge clk) if (start_o) n_start++;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(logic [7:0] exp, string req);
    oe_ni = 1'b0; cyc(4);
    chk(data_oe_o == 1'b1, "R4", "enable while oe low", data_oe_o, 1);
    chk(data_o == exp, req, "data byte", data_o, exp);
    oe_ni = 1'b1; cyc(4);
    chk(data_oe_o == 1'b0, "R4", "release after oe high", data_oe_o, 0);
  endtask

  task automatic conv_run(logic [23:0] eng, logic [23:0] exp, string req);
    int s0;
    s0 = n_start;
    conv_ni = 1'b0; cyc(5);
    chk(status_o == 2'b00, "R1", "status after start", status_o, 0);
    chk(n_start == s0 + 1, "R1", "start pulses", n_start - s0, 1);
    conv_ni = 1'b1; cyc(3);
    result_i = eng; done_i = 1'b1; cyc(1); done_i = 1'b0; cyc(2);
    chk(status_o == 2'b01, "R2", "status after done", status_o, 1);
    read_byte(exp[23:16], req);
    conv_ni = 1'b0; cyc(4); conv_ni = 1'b1; cyc(4);
    chk(status_o == 2'b10, "R3", "status mid", status_o, 2);
    read_byte(exp[15:8], req);
    conv_ni = 1'b0; cyc(4); conv_ni = 1'b1; cyc(4);
    chk(status_o == 2'b11, "R3", "status ready", status_o, 3);
    read_byte(exp[7:0], req);
  endtask

  task automatic mode_write(logic [7:0] b);
    data_i = b; mode_i = 1'b1; cyc(3);
    oe_ni = 1'b0; cyc(4);
    chk(data_oe_o == 1'b0, "R4", "no drive during mode write", data_oe_o, 0);
    oe_ni = 1'b1; cyc(4);
  endtask

  task automatic t_reset;
    cyc(2);
    chk(status_o == 2'b00, "R8", "status in reset az", status_o, 0);
    chk(az_o == 1'b1, "R8", "az_o after reset", az_o, 1);
    chk(res_o == 3'b011, "R8", "default res", res_o, 3);
    chk(data_oe_o == 1'b0, "R4", "bus idle at reset", data_oe_o, 0);
    cyc(AZ_CYC + 6);
    chk(status_o == 2'b11, "R8", "ready after az", status_o, 3);
    chk(az_o == 1'b0, "R8", "az_o released", az_o, 0);
  endtask

  task automatic t_mode_apply(logic [7:0] b);
    int s0;
    mode_write(b);
    s0 = n_start;
    conv_ni = 1'b0; cyc(4);
    chk(status_o == 2'b00, "R6", "status low while settling", status_o, 0);
    chk(res_o == b[2:0], "R5", "res field", res_o, b[2:0]);
    chk(line50_o == b[3], "R5", "line field", line50_o, b[3]);
    chk(src_o == b[5:4], "R5", "src field", src_o, b[5:4]);
    conv_ni = 1'b1; mode_i = 1'b0; cyc(SETTLE_CYC + 4);
    chk(n_start == s0, "R6", "no conversion on apply", n_start - s0, 0);
    chk(status_o == 2'b11, "R6", "ready after settle", status_o, 3);
  endtask

  task automatic t_reserved;
    mode_write(8'h0D);
    mode_i = 1'b0;
    conv_run(24'hFFFFFF, 24'h03FFFF, "R9");
    chk(res_o == 3'b001, "R7", "res kept", res_o, 1);
    chk(line50_o == 1'b1, "R7", "line kept", line50_o, 1);
    conv_run(24'h000000, 24'h000000, "R9");
  endtask

  task automatic t_done_ignored;
    result_i = 24'hABCDEF; done_i = 1'b1; cyc(1); done_i = 1'b0; cyc(3);
    chk(status_o == 2'b11, "R10", "status unchanged", status_o, 3);
    read_byte(8'h00, "R10");
  endtask

  task automatic t_autozero;
    az_ni = 1'b0; cyc(4);
    chk(status_o == 2'b00, "R8", "status during az", status_o, 0);
    chk(az_o == 1'b1, "R8", "az_o asserted", az_o, 1);
    chk(res_o == 3'b011, "R8", "res default", res_o, 3);
    chk(line50_o == 1'b0, "R8", "line default", line50_o, 0);
    chk(src_o == 2'b00, "R8", "src default", src_o, 0);
    az_ni = 1'b1; cyc(4);
    chk(az_o == 1'b1, "R8", "az held after release", az_o, 1);
    cyc(AZ_CYC + 4);
    chk(status_o == 2'b11, "R8", "ready after az", status_o, 3);
  endtask

  initial begin
    cyc(3); rst_ni = 1'b1;
    t_reset();
    conv_run(24'hE00000, 24'h200000, "R9");
    t_mode_apply(8'hD4);
    conv_run(24'h800000, 24'h800000, "R2");
    t_mode_apply(8'h09);
    t_reserved();
    t_done_ignored();
    t_autozero();
    conv_run(24'hFFFFFF, 24'h3FFFFF, "R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule